// File: doc/BRIEF.md
# Eight-Lane Pipelined Sorting Network

The block puts eight unsigned words into ascending order every clock cycle. A vector enters as one flat bus with a qualifying valid flag. It moves through seven registered columns of two-input min/max cells and leaves, fully ordered, exactly seven cycles later with its own valid flag. Lane `i` of either bus occupies bits `[i*W +: W]`. The element width `W` is a parameter.

The first four columns sort each half of the vector on its own and then merge the halves pairwise. After that point the largest word sits in lane 7 and the smallest in lane 0, but the lanes between them may still be out of order. Three further columns finish the job. Each one works only on the centre lanes: six lanes in column five, four in column six, and the middle two in column seven.

The stream interface has no back-pressure. There is no ready signal: the block accepts whatever is presented with `in_valid` high on every edge, and the sink must take each result in the cycle `out_valid` is high.

Top module: `sort8_pipe`

## Requirements
- R1: Whenever `out_valid` is high, the eight output lanes are in non-decreasing order, with lane 0 holding the minimum and lane 7 the maximum.
- R2: Each output vector holds exactly the same multiset of values as the input vector it came from. Only the order changes.
- R3: `out_valid` equals `in_valid` delayed by exactly seven clock edges, and the data that appears with it belongs to the vector accepted seven edges earlier.
- R4: A new vector can be accepted on every edge with no stall. Back-to-back vectors leave on consecutive cycles in the order they arrived.
- R5: A synchronous active-high `rst` clears the valid pipeline. `out_valid` is low while reset is held and for seven cycles afterwards, and vectors that were in flight when reset arrived never appear.
- R6: Each of the 256 zero-one input patterns comes out sorted. Bit `i` of the pattern sets lane `i` to all-ones; a clear bit sets it to zero.
- R7: Duplicate values are kept. An all-equal vector comes out unchanged, and repeated values appear in the output as often as they appear in the input.
- R8: The extreme values 0 and 2^W-1 are ordered correctly, and the largest input always leaves in lane 7.
- R9: Data presented while `in_valid` is low has no effect: it never produces an `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a vector to sort on this edge |
| in_data | input | 8*W | Eight unsigned lanes; lane `i` at bits `[i*W +: W]` |
| out_valid | output | 1 | Marks `out_data` as a sorted result |
| out_data | output | 8*W | Sorted lanes, ascending from lane 0 |

## Verification
Once a stream has run for seven cycles, accepting a new vector and delivering an older one happen on the same edge. The bench provokes this by driving the 256 zero-one patterns and several hundred random vectors back to back, some with gaps. Each result is judged against a reference sort of its own input, and the gap between issue and delivery is checked to be exactly seven cycles. A second collision is provoked by asserting reset while vectors are still in the columns; it is judged by `out_valid` staying low throughout reset and the following cycles.

// File: rtl/sort8_pkg.sv
package sort8_pkg;

  localparam int LANES   = 8;
  localparam int COLUMNS = 7;

  // Partner lane of `lane` in column `col`, or -1 when the lane passes straight through.
  // Columns 0..2 sort each half of four lanes; column 3 merges the halves lane by lane,
  // which leaves the minimum in lane 0 and the maximum in lane 7. Columns 4..6 shrink
  // towards the centre and finish the order.
  function automatic int partner(input int col, input int lane);
    int p;
    p = -1;
    case (col)
      0: p = lane ^ 1;
      1: p = lane ^ 2;
      2: begin
        case (lane)
          1: p = 2;
          2: p = 1;
          5: p = 6;
          6: p = 5;
          default: p = -1;
        endcase
      end
      3: p = lane ^ 4;
      4: begin
        if (lane >= 1 && lane <= 3)      p = lane + 3;
        else if (lane >= 4 && lane <= 6) p = lane - 3;
        else                             p = -1;
      end
      5: begin
        case (lane)
          2: p = 4;
          3: p = 5;
          4: p = 2;
          5: p = 3;
          default: p = -1;
        endcase
      end
      6: begin
        case (lane)
          3: p = 4;
          4: p = 3;
          default: p = -1;
        endcase
      end
      default: p = -1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/cx_cell.sv
module cx_cell #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic swap;

  assign swap = (b < a);
  assign lo   = swap ? b : a;
  assign hi   = swap ? a : b;
endmodule

// File: rtl/cx_column.sv
module cx_column
  import sort8_pkg::*;
#(
  parameter int W   = 16,
  parameter int COL = 0
) (
  input  logic               clk,
  input  logic [LANES*W-1:0] d,
  output logic [LANES*W-1:0] q
);
  logic [W-1:0] nxt [LANES];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    localparam int P = partner(COL, ln);
    if (P < 0) begin : g_pass
      assign nxt[ln] = d[ln*W +: W];
    end else if (ln < P) begin : g_cell
      cx_cell #(.W(W)) u_cell (
        .a (d[ln*W +: W]),
        .b (d[P*W +: W]),
        .lo(nxt[ln]),
        .hi(nxt[P])
      );
    end
  end

  // Data registers carry no reset: only the valid pipeline decides what is meaningful.
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) q[i*W +: W] <= nxt[i];
  end
endmodule

// File: rtl/valid_delay.sv
module valid_delay #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[DEPTH-2:0], din};
  end

  assign dout = sh[DEPTH-1];
endmodule

// File: rtl/sort8_pipe.sv
module sort8_pipe
  import sort8_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [LANES*W-1:0] in_data,
  output logic               out_valid,
  output logic [LANES*W-1:0] out_data
);
  logic [LANES*W-1:0] stage [COLUMNS+1];

  assign stage[0] = in_data;

  for (genvar c = 0; c < COLUMNS; c++) begin : g_col
    cx_column #(.W(W), .COL(c)) u_col (
      .clk(clk),
      .d  (stage[c]),
      .q  (stage[c+1])
    );
  end

  valid_delay #(.DEPTH(COLUMNS)) u_vld (
    .clk (clk),
    .rst (rst),
    .din (in_valid),
    .dout(out_valid)
  );

  assign out_data = stage[COLUMNS];
endmodule

// File: rtl/sort8_pipe_chk.sv
module sort8_pipe_chk
  import sort8_pkg::*;
#(
  parameter int W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [LANES*W-1:0] in_data,
  input logic               out_valid,
  input logic [LANES*W-1:0] out_data
);
  logic [3:0]   age;
  logic [W+2:0] in_sum, out_sum;
  logic [W-1:0] in_max;
  logic         ordered;

  always_ff @(posedge clk) begin
    if (rst)                    age <= '0;
    else if (age < 4'(COLUMNS)) age <= age + 4'd1;
  end

  always_comb begin
    in_sum  = '0;
    out_sum = '0;
    in_max  = '0;
    ordered = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      in_sum  = in_sum  + (W+3)'(in_data[i*W +: W]);
      out_sum = out_sum + (W+3)'(out_data[i*W +: W]);
      if (in_data[i*W +: W] > in_max) in_max = in_data[i*W +: W];
    end
    for (int i = 0; i < LANES-1; i++)
      if (out_data[i*W +: W] > out_data[(i+1)*W +: W]) ordered = 1'b0;
  end

  // R5
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (age < 4'(COLUMNS)) |-> !out_valid);

  // R3
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 4'(COLUMNS)) |-> (out_valid == $past(in_valid, COLUMNS)));

  // R1
  ascending_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ordered);

  // R2
  sum_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && age == 4'(COLUMNS)) |-> (out_sum == $past(in_sum, COLUMNS)));

  // R8
  top_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && age == 4'(COLUMNS)) |->
      (out_data[(LANES-1)*W +: W] == $past(in_max, COLUMNS)));
endmodule

bind sort8_pipe sort8_pipe_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/tb_sort8_pipe.sv
`timescale 1ns/1ps
module tb_sort8_pipe;
  localparam int W = 16;
  localparam int N = 8;
  localparam int LAT = 7;
  localparam int NROW = 6;

  localparam int TIN [NROW][N] = '{
    '{7, 6, 5, 4, 3, 2, 1, 0},
    '{0, 1, 2, 3, 4, 5, 6, 7},
    '{5, 5, 5, 5, 5, 5, 5, 5},
    '{3, 1, 4, 2, 0, 5, 80, 99},
    '{65535, 0, 65535, 0, 1, 65534, 32768, 32767},
    '{10, 3, 10, 3, 7, 7, 1, 10}
  };
  localparam int TEXP [NROW][N] = '{
    '{0, 1, 2, 3, 4, 5, 6, 7},
    '{0, 1, 2, 3, 4, 5, 6, 7},
    '{5, 5, 5, 5, 5, 5, 5, 5},
    '{0, 1, 2, 3, 4, 5, 80, 99},
    '{0, 0, 1, 32767, 32768, 65534, 65535, 65535},
    '{1, 3, 3, 7, 7, 10, 10, 10}
  };
  localparam string TTAG [NROW] = '{"R1 reversed", "R1 presorted", "R7 all equal",
                                    "R2 top two at end", "R8 extremes", "R7 duplicates"};

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] in_data = '0;
  logic           out_valid;
  logic [N*W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [N*W-1:0] exp_q [$];
  int             stamp_q [$];
  string          tag_q [$];

  sort8_pipe #(.W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [N*W-1:0] pack(input int a [N]);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(a[i]);
    return v;
  endfunction

  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0; j--)
        if (a[j] < a[j-1]) begin t = a[j]; a[j] = a[j-1]; a[j-1] = t; end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  function automatic bit is_sorted(input logic [N*W-1:0] v);
    for (int i = 0; i < N-1; i++)
      if (v[i*W +: W] > v[(i+1)*W +: W]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic send(input logic [N*W-1:0] v, input logic [N*W-1:0] expv, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = v;
    exp_q.push_back(expv);
    stamp_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_data  = {$urandom(), $urandom(), $urandom(), $urandom()};
    end
  endtask

  task automatic drain();
    idle(1);
    while (exp_q.size() != 0) @(negedge clk);
    idle(2);
  endtask

  // Output monitor: content (R2), order (R1), latency (R3), no stray results (R9).
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", out_data, '0);
      end else begin
        logic [N*W-1:0] e;
        int st;
        string tg;
        e  = exp_q.pop_front();
        st = stamp_q.pop_front();
        tg = tag_q.pop_front();
        check(out_data == e, {"R2 ", tg}, out_data, e);
        check(is_sorted(out_data), {"R1 ", tg}, out_data, e);
        check(cyc - st == LAT, {"R3 latency ", tg}, (N*W)'(cyc - st), (N*W)'(LAT));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R5: held reset keeps out_valid low
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5 during reset", {127'b0, out_valid}, '0);
    @(posedge clk); #1 rst = 1'b0;

    // R5: quiet for the latency window after release
    for (int k = 0; k < LAT; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R5 after release", {127'b0, out_valid}, '0);
    end

    // Table walk
    for (int t = 0; t < NROW; t++) send(pack(TIN[t]), pack(TEXP[t]), TTAG[t]);
    drain();

    // R6, R4: every zero-one pattern back to back
    for (int p = 0; p < 256; p++) begin
      logic [N*W-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = p[i] ? {W{1'b1}} : '0;
      send(v, ref_sort(v), "R6 R4 zero-one");
    end
    drain();

    // R2, R4: random vectors with occasional gaps and narrow ranges for duplicates
    for (int n = 0; n < 400; n++) begin
      logic [N*W-1:0] v;
      bit narrow;
      narrow = ($urandom_range(0, 3) == 0);
      for (int i = 0; i < N; i++)
        v[i*W +: W] = narrow ? W'($urandom_range(0, 3)) : W'($urandom());
      send(v, ref_sort(v), "R2 random");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    drain();

    // R9: data with in_valid low produces nothing
    for (int k = 0; k < 12; k++) begin
      idle(1);
      @(negedge clk);
      check(out_valid == 1'b0, "R9 invalid input ignored", {127'b0, out_valid}, '0);
    end

    // R5: reset while vectors are in flight drops them
    for (int k = 0; k < 3; k++) send(pack(TIN[0]), pack(TEXP[0]), "R5 flushed");
    @(posedge clk); #1;
    rst = 1'b1;
    in_valid = 1'b0;
    exp_q.delete();
    stamp_q.delete();
    tag_q.delete();
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R5 in-flight dropped", {127'b0, out_valid}, '0);
    end

    // R8: maximum value alone, in lane 0
    begin
      logic [N*W-1:0] v;
      v = '0;
      v[W-1:0] = {W{1'b1}};
      send(v, ref_sort(v), "R8 max from lane 0");
    end
    drain();

    check(exp_q.size() == 0, "R4 all results delivered", (N*W)'(exp_q.size()), '0);
    finish_run();
  end
endmodule